// File: doc/BRIEF.md
# Serial Flash Deep Sleep and Wake Controller

This block is the slave-side command logic that decides whether a serial flash device is asleep, awake, or on its way back to standby. It watches the four-wire serial bus (select, serial clock, data in) through a system-clock synchronizer. It decodes the sleep command and the combined wake/identify command, and it shifts out a one-byte device identifier. A busy input stands for any write, erase or status-write cycle running elsewhere in the device. All other opcodes are not acted on here.

When asleep, the block acts on nothing but the wake/identify opcode. That command can also be issued while awake, where it only returns the identifier. When it ends a sleep period, the block holds off new frames for a recovery time. That time is short if select rose before one whole identifier byte had gone out, and long otherwise. Recovery times are counted in system clock cycles. While a recovery time is pending, `ready` is low and any frame started then is dropped. The serial interface has no flow control: the bus master paces every bit, so no valid/ready handshake applies and all pins are plain level signals.

Top module: `spi_pd_wake_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `in_power_down` is 0 and `spi_miso_oe` is 0.
- R2: A frame of exactly 8 bits carrying opcode 0xB9 (MSB first), closed by select rising while awake and with `busy_i` low, sets `in_power_down` to 1. The same opcode followed by a ninth bit, or sent while `busy_i` is high, leaves it at 0.
- R3: While `in_power_down` is 1, any opcode other than 0xAB produces no output (`spi_miso_oe` stays 0), leaves `in_power_down` at 1 and does not lower `ready`.
- R4: Opcode 0xAB is followed by 24 don't-care bits. On the falling clock edge after the 32nd rising edge, the block starts driving identifier 0x10 MSB first. Each bit changes on a falling edge and is valid at the next rising edge. When the device is awake, the frame does not lower `ready`.
- R5: While select stays low and clocks continue, the identifier byte 0x10 is sent again and again.
- R6: If `busy_i` is high when the eighth opcode bit is sampled, opcode 0xAB is not decoded: nothing is driven and the power state does not change.
- R7: If the device is asleep and select rises after at least 40 rising clock edges of a 0xAB frame, `in_power_down` clears and `ready` is low for exactly `TRES_LONG` system clock cycles.
- R8: If the device is asleep and select rises after the eighth but before the fortieth rising edge of a 0xAB frame, `in_power_down` clears and `ready` is low for exactly `TRES_SHORT` cycles.
- R9: A 0xAB frame closed after fewer than 8 bits has no effect on a sleeping device.
- R10: A frame whose select falls while `ready` is 0 is ignored, including a sleep command.
- R11: `spi_miso_oe` is 0 whenever select is high and during the opcode and don't-care bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data into the device |
| busy_i | input | 1 | High while a write, erase or status-write cycle runs |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| in_power_down | output | 1 | High while the device is in deep sleep |
| ready | output | 1 | High in standby; low during a wake recovery time |

## Verification
A wrong bit count or opcode register shows within the same frame: the identifier appears a byte early or late, or not at all. The output enable may also rise during the don't-care bits. A wrong sleep flag shows at the close of the next frame, either as a missing or extra recovery period on `ready` or as a wrong `in_power_down` level. Off-by-one errors in the recovery counter show only as a `ready` low time one cycle off. For that reason, the bench measures the low time exactly.

// File: rtl/spi_pd_pkg.sv
`timescale 1ns/1ps
package spi_pd_pkg;
  localparam int          OP_W        = 8;
  localparam int          ID_W        = 8;
  localparam int          DUMMY_BYTES = 3;
  localparam logic [7:0]  OP_WAKE_ID  = 8'hAB;
  localparam logic [7:0]  OP_SLEEP    = 8'hB9;
  localparam logic [7:0]  DEV_ID      = 8'h10;
endpackage

// File: rtl/spi_pd_sync.sv
`timescale 1ns/1ps
// Brings select, clock and data into the system clock domain through
// identical chains, so data stays aligned with the detected clock edge.
module spi_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b100;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] last, last_d;

  assign raw = {cs_n_i, sck_i, mosi_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= IDLE_VAL;
      last_d <= IDLE_VAL;
    end else begin
      chain[0] <= raw;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      last_d <= last;
    end
  end

  assign last     = chain[STAGES-1];
  assign cs_s     = last[2];
  assign mosi_s   = last[0];
  assign sck_rise = last[1] & ~last_d[1] & ~last[2];
  assign sck_fall = ~last[1] & last_d[1] & ~last[2];
  assign cs_rise  = last[2] & ~last_d[2];
  assign cs_fall  = ~last[2] & last_d[2];
endmodule

// File: rtl/spi_pd_cmd_engine.sv
`timescale 1ns/1ps
// Frame decoder: bit counting, opcode capture, identifier shifting and
// the end-of-frame requests for sleep and wake.
module spi_pd_cmd_engine
  import spi_pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_rise,
  input  logic cs_fall,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic mosi_s,
  input  logic busy_i,
  input  logic pdown_i,
  input  logic ready_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic wake_long_o,
  output logic wake_short_o,
  output logic sleep_o
);
  localparam int HDR_BITS = OP_W + DUMMY_BYTES * 8;
  localparam int MAX_CNT  = HDR_BITS + ID_W;
  localparam int CW       = $clog2(MAX_CNT + 1);
  localparam int PW       = $clog2(ID_W);

  logic          active_q, res_q, drive_q, miso_q;
  logic [CW-1:0] bits_q;
  logic [7:0]    shift_q, op_q, shift_next;
  logic [PW-1:0] id_pos_q;
  logic          at_end, id_sent;

  assign shift_next = {shift_q[6:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      res_q    <= 1'b0;
      drive_q  <= 1'b0;
      miso_q   <= 1'b0;
      bits_q   <= '0;
      shift_q  <= '0;
      op_q     <= '0;
      id_pos_q <= '0;
    end else if (cs_fall) begin
      active_q <= ready_i;
      res_q    <= 1'b0;
      drive_q  <= 1'b0;
      bits_q   <= '0;
      op_q     <= '0;
      id_pos_q <= '0;
    end else if (cs_rise) begin
      active_q <= 1'b0;
      res_q    <= 1'b0;
      drive_q  <= 1'b0;
    end else if (active_q) begin
      if (sck_rise) begin
        shift_q <= shift_next;
        if (bits_q != CW'(MAX_CNT)) bits_q <= bits_q + 1'b1;
        if (bits_q == CW'(OP_W - 1)) begin
          op_q  <= shift_next;
          res_q <= (shift_next == OP_WAKE_ID) && !busy_i;
        end
      end
      if (sck_fall && res_q && (bits_q >= CW'(HDR_BITS))) begin
        drive_q  <= 1'b1;
        miso_q   <= DEV_ID[PW'(ID_W - 1) - id_pos_q];
        id_pos_q <= id_pos_q + 1'b1;
      end
    end
  end

  assign at_end       = cs_rise & active_q;
  assign id_sent      = (bits_q == CW'(MAX_CNT));
  assign wake_long_o  = at_end & res_q & pdown_i & id_sent;
  assign wake_short_o = at_end & res_q & pdown_i & ~id_sent;
  assign sleep_o      = at_end & ~pdown_i & ~busy_i &
                        (bits_q == CW'(OP_W)) & (op_q == OP_SLEEP);
  assign miso_o       = miso_q;
  assign miso_oe_o    = drive_q;

  assert_res_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_q) |-> !$past(busy_i));
  assert_oe_off_after_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !drive_q);
  assert_one_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_long_o, wake_short_o, sleep_o}));
endmodule

// File: rtl/spi_pd_wake_timer.sv
`timescale 1ns/1ps
// Recovery counter: loaded with the short or long delay, counts to zero.
module spi_pd_wake_timer #(
  parameter int unsigned SHORT_CYC = 100,
  parameter int unsigned LONG_CYC  = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_short,
  input  logic start_long,
  output logic ready_o
);
  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start_long)    cnt_q <= CW'(LONG_CYC);
    else if (start_short)   cnt_q <= CW'(SHORT_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !start_short && !start_long) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/spi_pd_wake_ctrl.sv
`timescale 1ns/1ps
module spi_pd_wake_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned TRES_SHORT  = 100,
  parameter int unsigned TRES_LONG   = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic busy_i,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic in_power_down,
  output logic ready
);
  logic cs_s, mosi_s, sck_rise, sck_fall, cs_rise, cs_fall;
  logic wake_long, wake_short, sleep_req;
  logic pdown_q;

  spi_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_s(cs_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  spi_pd_cmd_engine u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s), .busy_i(busy_i),
    .pdown_i(pdown_q), .ready_i(ready),
    .miso_o(spi_miso), .miso_oe_o(spi_miso_oe),
    .wake_long_o(wake_long), .wake_short_o(wake_short),
    .sleep_o(sleep_req)
  );

  spi_pd_wake_timer #(.SHORT_CYC(TRES_SHORT), .LONG_CYC(TRES_LONG)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start_short(wake_short), .start_long(wake_long),
    .ready_o(ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pdown_q <= 1'b0;
    else if (sleep_req)                pdown_q <= 1'b1;
    else if (wake_long || wake_short)  pdown_q <= 1'b0;
  end

  assign in_power_down = pdown_q;

  assert_quiet_while_waking_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !spi_miso_oe);
  assert_exit_starts_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pdown_q) |-> !ready);
  assert_oe_needs_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !spi_miso_oe);
endmodule

// File: tb/tb_spi_pd_wake_ctrl.sv
`timescale 1ns/1ps
module tb_spi_pd_wake_ctrl;
  localparam int TS = 40;
  localparam int TL = 300;
  localparam int HALF = 8;
  localparam int NV = 12;

  // {pd_before, busy, opcode, nbits, exp_oe, exp_pd_after, delay(0 none,1 short,2 long)}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hAB, 6'd40, 1'b1, 1'b0, 2'd0},
    {1'b0, 1'b0, 8'hAB, 6'd56, 1'b1, 1'b0, 2'd0},
    {1'b0, 1'b1, 8'hAB, 6'd40, 1'b0, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'h9F, 6'd40, 1'b0, 1'b1, 2'd0},
    {1'b1, 1'b0, 8'hAB, 6'd48, 1'b1, 1'b0, 2'd2},
    {1'b1, 1'b0, 8'hAB, 6'd8,  1'b0, 1'b0, 2'd1},
    {1'b1, 1'b0, 8'hAB, 6'd36, 1'b1, 1'b0, 2'd1},
    {1'b0, 1'b0, 8'hB9, 6'd8,  1'b0, 1'b1, 2'd0},
    {1'b0, 1'b0, 8'hB9, 6'd9,  1'b0, 1'b0, 2'd0},
    {1'b0, 1'b1, 8'hB9, 6'd8,  1'b0, 1'b0, 2'd0},
    {1'b1, 1'b0, 8'hAB, 6'd4,  1'b0, 1'b1, 2'd0},
    {1'b1, 1'b0, 8'hB9, 6'd8,  1'b0, 1'b1, 2'd0}
  };
  localparam string TAG [NV] = '{"R4", "R5", "R6", "R3", "R7", "R8",
                                 "R8", "R2", "R2", "R2", "R9", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, busy_i = 1'b0;
  logic spi_miso, spi_miso_oe, in_power_down, ready;

  int checks = 0;
  int failures = 0;
  logic [7:0] rd [8];
  int  nread, lowcnt;
  bit  oe_seen, oe_early;

  always #10 clk = ~clk;  // 50 MHz

  spi_pd_wake_ctrl #(.TRES_SHORT(TS), .TRES_LONG(TL)) dut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .busy_i(busy_i), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .in_power_down(in_power_down), .ready(ready)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame of nbits; data is op MSB first then zeros. Reads miso just
  // before every rising edge from bit 32 on.
  task automatic xfer(input logic [7:0] op, input int nbits, input bit measure);
    logic [7:0] sr;
    sr = '0; nread = 0; oe_seen = 0; oe_early = 0; lowcnt = 0;
    spi_cs_n = 1'b0;
    waitc(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 8) ? op[7-i] : 1'b0;
      waitc(HALF);
      if (spi_miso_oe) begin
        oe_seen = 1;
        if (i < 32) oe_early = 1;
      end
      if (i >= 32) sr = {sr[6:0], spi_miso};
      spi_sck = 1'b1;
      waitc(HALF);
      spi_sck = 1'b0;
      if (i >= 32 && ((i - 32) % 8) == 7 && nread < 8) begin
        rd[nread] = sr;
        nread++;
      end
    end
    waitc(HALF);
    spi_cs_n = 1'b1;
    if (measure) begin
      for (int k = 0; k < TL + 40; k++) begin
        @(negedge clk);
        if (!ready) lowcnt++;
        else if (lowcnt > 0) break;
      end
    end else begin
      waitc(4);
    end
  endtask

  task automatic set_pd(input logic want);
    if (in_power_down != want) begin
      if (want) xfer(8'hB9, 8, 1'b1);
      else      xfer(8'hAB, 8, 1'b1);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [19:0] v;
    int expd;
    waitc(3);
    // R1: reset state
    check("R1", ready, 1, "ready after reset");
    check("R1", in_power_down, 0, "power-down after reset");
    check("R1", spi_miso_oe, 0, "oe during reset");
    rst_n = 1'b1;
    waitc(5);
    check("R1", ready, 1, "ready after release");
    check("R1", in_power_down, 0, "power-down after release");
    check("R11", spi_miso_oe, 0, "oe idle select high");

    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      set_pd(v[19]);
      busy_i = v[18];
      xfer(v[17:10], int'(v[9:4]), 1'b1);
      busy_i = 1'b0;
      expd = (v[1:0] == 2'd2) ? TL : (v[1:0] == 2'd1) ? TS : 0;
      check(TAG[n], int'(oe_seen), int'(v[3]), $sformatf("vector %0d output enable seen", n));
      check("R11", int'(oe_early), 0, $sformatf("vector %0d oe during header", n));
      check(TAG[n], int'(in_power_down), int'(v[2]), $sformatf("vector %0d power state", n));
      check(TAG[n], lowcnt, expd, $sformatf("vector %0d ready low cycles", n));
      check("R11", spi_miso_oe, 0, $sformatf("vector %0d oe after select high", n));
      if (v[3]) begin
        for (int b = 0; b < nread; b++)
          check((b > 0) ? "R5" : "R4", rd[b], 8'h10, $sformatf("vector %0d id byte %0d", n, b));
      end
    end

    // R10: sleep command sent during a pending long delay is ignored
    set_pd(1'b1);
    xfer(8'hAB, 40, 1'b0);
    check("R7", ready, 0, "ready low right after wake");
    xfer(8'hB9, 8, 1'b0);
    check("R10", int'(oe_seen), 0, "no output in delay frame");
    wait (ready === 1'b1);
    waitc(4);
    check("R10", in_power_down, 0, "sleep ignored during delay");

    // R10: identify frame during short delay produces no output
    set_pd(1'b1);
    xfer(8'hAB, 8, 1'b0);
    xfer(8'hAB, 40, 1'b0);
    check("R10", int'(oe_seen), 0, "identify ignored during delay");
    wait (ready === 1'b1);
    waitc(4);

    // R1: reset in the middle of sleep returns to awake state
    set_pd(1'b1);
    check("R2", in_power_down, 1, "asleep before reset");
    rst_n = 1'b0;
    waitc(2);
    check("R1", in_power_down, 0, "reset clears sleep");
    check("R1", ready, 1, "ready in reset");
    rst_n = 1'b1;
    waitc(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule